// File: doc/BRIEF.md
# Nested Active Interrupt Completion Tracker

This block keeps, for each processor, a record of which interrupt is being serviced and which ones it preempted. When a processor takes an interrupt, the block stores the ID that was running before it in a link table and makes the new ID the running one. When the processor signals end-of-interrupt, the block does one of two things. If the completed ID is the running one, its stored predecessor becomes the running ID again. If the completed ID sits deeper in the nest, the block walks the chain and splices that ID out, and the running ID stays as it is. The ID value 1023 means that nothing is running.

At an end-of-interrupt the block also checks the completed interrupt. If that interrupt is level-sensitive, enabled, routed to the completing processor and its input line is still high, the block sends a one-cycle re-pend strobe, so that the pending logic outside can mark it pending again for that processor. The block does not choose priorities and does not decode registers. It sits between the acknowledge/completion path of each processor interface and the pending-state store.

The link table is one memory of NIRQ x NCPU entries, each 10 bits wide. After reset the block clears the table one entry per clock. The chain walk also reads one link per clock. While either of these runs, `busy` is high and the block drops any acknowledge or end-of-interrupt that arrives.

Top module: `irq_nest_tracker`

## Requirements
- R1: After reset every running ID reads 1023. `busy` stays high while the link table is cleared, one entry per clock. It drops on the NIRQ*NCPU-th clock after reset is released.
- R2: An acknowledge taken while `busy` is low, with an ID below NIRQ, makes that ID the running ID of the addressed processor on the next cycle. It also records the previous running ID as the link of the new ID.
- R3: An acknowledge with an ID of NIRQ or above (1023 included) changes nothing.
- R4: When a valid acknowledge and an end-of-interrupt arrive in the same cycle, the acknowledge is carried out and the end-of-interrupt is dropped.
- R5: An end-of-interrupt for a processor whose running ID is 1023 is dropped. There is no change of running ID, no strobe and no busy cycle.
- R6: An end-of-interrupt naming the running ID holds `busy` high for one cycle. The running ID then becomes the stored predecessor, which is 1023 when the nest is empty.
- R7: An end-of-interrupt naming an ID at depth p below the running one (p >= 1) holds `busy` high for p+1 cycles. The running ID does not change. The completed ID is removed from the chain, so later completions skip it.
- R8: An end-of-interrupt naming an ID that is not in the chain (1023 included) walks the whole chain. `busy` stays high for as many cycles as the chain has entries, and the chain does not change.
- R9: One cycle after an end-of-interrupt is accepted, `repend_valid` pulses with the processor and ID when all of these hold: the ID is below NIRQ, `irq_edge` for that ID is 0 (level-sensitive), `irq_enable` is 1, `irq_level` is 1, and bit ID*NCPU+cpu of `irq_target` is 1. Otherwise the strobe stays low.
- R10: The completed ID is bits [9:0] of `eoi_data`. Bits [31:10] have no effect.
- R11: While `busy` is high, any acknowledge or end-of-interrupt is dropped.
- R12: The chains of different processors are independent. An operation on one processor never changes another processor's running ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_cpu | input | CW | Processor taking the interrupt |
| ack_id | input | 10 | Interrupt ID being taken |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_cpu | input | CW | Processor completing an interrupt |
| eoi_data | input | 32 | Written completion word; ID in bits [9:0] |
| irq_level | input | NIRQ | Current input line level per interrupt |
| irq_edge | input | NIRQ | 1 = edge-sensitive, 0 = level-sensitive |
| irq_enable | input | NIRQ | Per-interrupt enable |
| irq_target | input | NIRQ*NCPU | Routing; bit id*NCPU+cpu |
| busy | output | 1 | Table clear or chain walk in progress |
| running_id | output | NCPU*10 | Running ID per processor; cpu c at bits [c*10 +: 10] |
| repend_valid | output | 1 | Re-pend strobe |
| repend_cpu | output | CW | Processor for the re-pend |
| repend_id | output | 10 | Interrupt to re-pend |

## Verification
The bench builds the block with NIRQ=16 and NCPU=2. With these values a single processor can nest every ID at once. This makes the longest walk, fifteen hops followed by a splice, as well as the full-chain miss, short enough to run. Two processors are enough to show that the chains stay separate and that only the routing bit of the completing processor counts for a re-pend. The 32-entry clear after reset takes little time, so the reset and clear timing is checked cycle by cycle.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int IDW = 10;
  localparam logic [IDW-1:0] NONE_ID = 10'h3FF;

  typedef enum logic [2:0] {
    S_INIT,
    S_IDLE,
    S_POP,
    S_WALK,
    S_FIX
  } nest_state_e;
endpackage

// File: rtl/irq_nest_link_ram.sv
// Single-port link table: synchronous read-first, suitable for block RAM.
module irq_nest_link_ram #(
  parameter int AW = 5,
  parameter int DW = 10,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rd
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    rd <= mem[addr];
  end
endmodule

// File: rtl/irq_nest_repend.sv
// Decides whether a completed interrupt must be marked pending again.
module irq_nest_repend #(
  parameter int NIRQ = 16,
  parameter int NCPU = 2,
  localparam int CW = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int IW = $clog2(NIRQ)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   accept,
  input  logic [CW-1:0]          cpu,
  input  logic [irq_nest_pkg::IDW-1:0] id,
  input  logic [NIRQ-1:0]        lvl,
  input  logic [NIRQ-1:0]        edge_mode,
  input  logic [NIRQ-1:0]        en,
  input  logic [NIRQ*NCPU-1:0]   tgt,
  output logic                   rp_valid,
  output logic [CW-1:0]          rp_cpu,
  output logic [irq_nest_pkg::IDW-1:0] rp_id
);
  import irq_nest_pkg::*;
  localparam logic [IDW-1:0] NIRQ_ID = IDW'(NIRQ);

  logic [NCPU-1:0] route [NIRQ];
  for (genvar i = 0; i < NIRQ; i++) begin : g_route
    assign route[i] = tgt[i*NCPU +: NCPU];
  end

  logic [IW-1:0] sid;
  logic          hit;
  assign sid = id[IW-1:0];

  always_comb begin
    hit = 1'b0;
    if (accept && (id < NIRQ_ID))
      hit = !edge_mode[sid] && en[sid] && lvl[sid] && route[sid][cpu];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rp_valid <= 1'b0;
      rp_cpu   <= '0;
      rp_id    <= NONE_ID;
    end else begin
      rp_valid <= hit;
      rp_cpu   <= cpu;
      rp_id    <= id;
    end
  end
endmodule

// File: rtl/irq_nest_ctrl.sv
// Running-ID registers and the clear / pop / walk / splice sequencer.
module irq_nest_ctrl #(
  parameter int NIRQ = 16,
  parameter int NCPU = 2,
  localparam int CW = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int IW = $clog2(NIRQ),
  localparam int AW = CW + IW
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ack_valid,
  input  logic [CW-1:0]                 ack_cpu,
  input  logic [irq_nest_pkg::IDW-1:0]  ack_id,
  input  logic                          eoi_valid,
  input  logic [CW-1:0]                 eoi_cpu,
  input  logic [irq_nest_pkg::IDW-1:0]  eoi_id,
  output logic                          mem_we,
  output logic [AW-1:0]                 mem_addr,
  output logic [irq_nest_pkg::IDW-1:0]  mem_wd,
  input  logic [irq_nest_pkg::IDW-1:0]  mem_rd,
  output logic                          eoi_accept,
  output logic                          busy,
  output logic [NCPU*irq_nest_pkg::IDW-1:0] running_id
);
  import irq_nest_pkg::*;
  localparam logic [IDW-1:0] NIRQ_ID = IDW'(NIRQ);
  localparam int SW = IW + 1;
  localparam logic [SW-1:0] STEP_LIM = SW'(NIRQ - 1);
  localparam logic [AW-1:0] LAST_ADDR = AW'(NIRQ * NCPU - 1);

  nest_state_e    st;
  logic [IDW-1:0] run_q [NCPU];
  logic [CW-1:0]  op_cpu;
  logic [IDW-1:0] op_id;
  logic [IDW-1:0] cur;
  logic [SW-1:0]  steps;
  logic [AW-1:0]  init_addr;

  logic [IDW-1:0] run_ack, run_eoi;
  logic           ack_go, eoi_go;
  logic           w_end, w_hit, w_lim;

  function automatic logic [AW-1:0] link_addr(input logic [CW-1:0] c,
                                              input logic [IDW-1:0] i);
    return {c, i[IW-1:0]};
  endfunction

  assign run_ack = run_q[ack_cpu];
  assign run_eoi = run_q[eoi_cpu];
  assign w_end   = (mem_rd >= NIRQ_ID);
  assign w_hit   = !w_end && (mem_rd == op_id);
  assign w_lim   = (steps == STEP_LIM);

  always_comb begin
    mem_we   = 1'b0;
    mem_addr = init_addr;
    mem_wd   = NONE_ID;
    ack_go   = 1'b0;
    eoi_go   = 1'b0;
    unique case (st)
      S_INIT: mem_we = 1'b1;
      S_IDLE: begin
        if (ack_valid && (ack_id < NIRQ_ID)) begin
          ack_go   = 1'b1;
          mem_we   = 1'b1;
          mem_addr = link_addr(ack_cpu, ack_id);
          mem_wd   = run_ack;
        end else if (eoi_valid && (run_eoi != NONE_ID)) begin
          eoi_go   = 1'b1;
          mem_addr = (eoi_id == run_eoi) ? link_addr(eoi_cpu, eoi_id)
                                         : link_addr(eoi_cpu, run_eoi);
        end
      end
      S_POP: ;
      S_WALK: begin
        if (w_hit) mem_addr = link_addr(op_cpu, op_id);
        else       mem_addr = link_addr(op_cpu, mem_rd);
      end
      S_FIX: begin
        mem_we   = 1'b1;
        mem_addr = link_addr(op_cpu, cur);
        mem_wd   = mem_rd;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_INIT;
      init_addr <= '0;
      op_cpu    <= '0;
      op_id     <= NONE_ID;
      cur       <= NONE_ID;
      steps     <= '0;
      for (int c = 0; c < NCPU; c++) run_q[c] <= NONE_ID;
    end else begin
      unique case (st)
        S_INIT: begin
          init_addr <= init_addr + 1'b1;
          if (init_addr == LAST_ADDR) st <= S_IDLE;
        end
        S_IDLE: begin
          if (ack_go) begin
            run_q[ack_cpu] <= ack_id;
          end else if (eoi_go) begin
            op_cpu <= eoi_cpu;
            op_id  <= eoi_id;
            cur    <= run_eoi;
            steps  <= '0;
            st     <= (eoi_id == run_eoi) ? S_POP : S_WALK;
          end
        end
        S_POP: begin
          run_q[op_cpu] <= mem_rd;
          st            <= S_IDLE;
        end
        S_WALK: begin
          if (w_end)      st <= S_IDLE;
          else if (w_hit) st <= S_FIX;
          else if (w_lim) st <= S_IDLE;
          else begin
            cur   <= mem_rd;
            steps <= steps + 1'b1;
          end
        end
        S_FIX:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy       = (st != S_IDLE);
  assign eoi_accept = eoi_go;

  for (genvar c = 0; c < NCPU; c++) begin : g_run
    assign running_id[c*IDW +: IDW] = run_q[c];
  end
endmodule

// File: rtl/irq_nest_tracker.sv
module irq_nest_tracker #(
  parameter int NIRQ = 64,
  parameter int NCPU = 4,
  localparam int CW = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int IW = $clog2(NIRQ),
  localparam int AW = CW + IW
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ack_valid,
  input  logic [CW-1:0]          ack_cpu,
  input  logic [9:0]             ack_id,
  input  logic                   eoi_valid,
  input  logic [CW-1:0]          eoi_cpu,
  input  logic [31:0]            eoi_data,
  input  logic [NIRQ-1:0]        irq_level,
  input  logic [NIRQ-1:0]        irq_edge,
  input  logic [NIRQ-1:0]        irq_enable,
  input  logic [NIRQ*NCPU-1:0]   irq_target,
  output logic                   busy,
  output logic [NCPU*10-1:0]     running_id,
  output logic                   repend_valid,
  output logic [CW-1:0]          repend_cpu,
  output logic [9:0]             repend_id
);
  import irq_nest_pkg::*;

  logic [IDW-1:0] eoi_id;
  logic           eoi_hi_unused;
  logic           mem_we;
  logic [AW-1:0]  mem_addr;
  logic [IDW-1:0] mem_wd, mem_rd;
  logic           eoi_accept;

  assign eoi_id        = eoi_data[IDW-1:0];
  assign eoi_hi_unused = ^eoi_data[31:IDW];

  irq_nest_ctrl #(.NIRQ(NIRQ), .NCPU(NCPU)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .ack_valid  (ack_valid),
    .ack_cpu    (ack_cpu),
    .ack_id     (ack_id),
    .eoi_valid  (eoi_valid),
    .eoi_cpu    (eoi_cpu),
    .eoi_id     (eoi_id),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wd     (mem_wd),
    .mem_rd     (mem_rd),
    .eoi_accept (eoi_accept),
    .busy       (busy),
    .running_id (running_id)
  );

  irq_nest_link_ram #(.AW(AW), .DW(IDW)) u_links (
    .clk  (clk),
    .we   (mem_we),
    .addr (mem_addr),
    .wd   (mem_wd),
    .rd   (mem_rd)
  );

  irq_nest_repend #(.NIRQ(NIRQ), .NCPU(NCPU)) u_repend (
    .clk       (clk),
    .rst       (rst),
    .accept    (eoi_accept),
    .cpu       (eoi_cpu),
    .id        (eoi_id),
    .lvl       (irq_level),
    .edge_mode (irq_edge),
    .en        (irq_enable),
    .tgt       (irq_target),
    .rp_valid  (repend_valid),
    .rp_cpu    (repend_cpu),
    .rp_id     (repend_id)
  );
endmodule

// File: rtl/irq_nest_tracker_chk.sv
module irq_nest_tracker_chk #(
  parameter int NIRQ = 64,
  parameter int NCPU = 4,
  localparam int CW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic               ack_valid,
  input logic [CW-1:0]      ack_cpu,
  input logic [9:0]         ack_id,
  input logic               eoi_valid,
  input logic [CW-1:0]      eoi_cpu,
  input logic [9:0]         eoi_id,
  input logic               busy,
  input logic [NCPU*10-1:0] running_id,
  input logic               repend_valid
);
  localparam logic [9:0] NONE = 10'h3FF;
  localparam logic [9:0] LIM  = 10'(NIRQ);

  logic [9:0] run_a [NCPU];
  for (genvar c = 0; c < NCPU; c++) begin : g_unpack
    assign run_a[c] = running_id[c*10 +: 10];

    p_running_legal_r2: assert property (@(posedge clk) disable iff (rst)
      (run_a[c] == NONE) || (run_a[c] < LIM));
  end

  logic ack_take;
  assign ack_take = ack_valid && (ack_id < LIM);

  p_clear_busy_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> busy);

  p_ack_takes_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && ack_take) |=> (run_a[$past(ack_cpu)] == $past(ack_id)));

  p_idle_eoi_dropped_r5: assert property (@(posedge clk) disable iff (rst)
    (!busy && !ack_take && eoi_valid && (run_a[eoi_cpu] == NONE))
      |=> (!busy && !repend_valid && $stable(running_id)));

  p_walk_keeps_running_r7: assert property (@(posedge clk) disable iff (rst)
    (!busy && !ack_take && eoi_valid && (run_a[eoi_cpu] != NONE)
      && (eoi_id != run_a[eoi_cpu])) |=> (busy && $stable(running_id)));

  p_repend_after_eoi_r9: assert property (@(posedge clk) disable iff (rst)
    repend_valid |-> ($past(eoi_valid) && !$past(busy)));
endmodule

bind irq_nest_tracker irq_nest_tracker_chk #(.NIRQ(NIRQ), .NCPU(NCPU)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ack_valid    (ack_valid),
  .ack_cpu      (ack_cpu),
  .ack_id       (ack_id),
  .eoi_valid    (eoi_valid),
  .eoi_cpu      (eoi_cpu),
  .eoi_id       (eoi_data[9:0]),
  .busy         (busy),
  .running_id   (running_id),
  .repend_valid (repend_valid)
);

// File: tb/irq_nest_tracker_bench.sv
module irq_nest_tracker_bench;
  localparam int NIRQ = 16;
  localparam int NCPU = 2;
  localparam int CW   = 1;
  localparam int NONE = 1023;
  localparam int T    = NIRQ * NCPU;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic                 ack_valid = 0;
  logic [CW-1:0]        ack_cpu = 0;
  logic [9:0]           ack_id = 0;
  logic                 eoi_valid = 0;
  logic [CW-1:0]        eoi_cpu = 0;
  logic [31:0]          eoi_data = 0;
  logic [NIRQ-1:0]      irq_level = 0;
  logic [NIRQ-1:0]      irq_edge = 0;
  logic [NIRQ-1:0]      irq_enable = 0;
  logic [NIRQ*NCPU-1:0] irq_target = 0;
  logic                 busy;
  logic [NCPU*10-1:0]   running_id;
  logic                 repend_valid;
  logic [CW-1:0]        repend_cpu;
  logic [9:0]           repend_id;

  irq_nest_tracker #(.NIRQ(NIRQ), .NCPU(NCPU)) u_irq_nest_tracker (
    .clk(clk), .rst(rst),
    .ack_valid(ack_valid), .ack_cpu(ack_cpu), .ack_id(ack_id),
    .eoi_valid(eoi_valid), .eoi_cpu(eoi_cpu), .eoi_data(eoi_data),
    .irq_level(irq_level), .irq_edge(irq_edge), .irq_enable(irq_enable),
    .irq_target(irq_target), .busy(busy), .running_id(running_id),
    .repend_valid(repend_valid), .repend_cpu(repend_cpu), .repend_id(repend_id)
  );

  int    total = 0;
  int    bad = 0;
  string tag = "R1 reset";
  bit    done = 0;

  // reference model: each queue holds the nest, front = running
  int q [NCPU][$];
  int exp_run [NCPU];
  int bcnt;
  bit pend_pop;
  int pend_cpu, pend_run;
  bit exp_rv;
  int exp_rc, exp_rid;

  function automatic void check(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endfunction

  function automatic void compare();
    for (int c = 0; c < NCPU; c++)
      check($sformatf("running cpu%0d", c), int'(running_id[c*10 +: 10]), exp_run[c]);
    check("busy", int'(busy), int'(bcnt > 0));
    check("repend_valid", int'(repend_valid), int'(exp_rv));
    if (exp_rv) begin
      check("repend_cpu", int'(repend_cpu), exp_rc);
      check("repend_id", int'(repend_id), exp_rid);
    end
  endfunction

  function automatic void model_step();
    int c, e, p;
    exp_rv = 0;
    if (bcnt > 0) begin
      bcnt--;
      if (bcnt == 0 && pend_pop) begin
        exp_run[pend_cpu] = pend_run;
        pend_pop = 0;
      end
    end else if (ack_valid && int'(ack_id) < NIRQ) begin
      q[ack_cpu].push_front(int'(ack_id));
      exp_run[ack_cpu] = int'(ack_id);
    end else if (eoi_valid && q[eoi_cpu].size() > 0) begin
      c = int'(eoi_cpu);
      e = int'(eoi_data & 32'h3FF);
      if (e < NIRQ && !irq_edge[e] && irq_enable[e] && irq_level[e]
          && irq_target[e*NCPU + c]) begin
        exp_rv = 1; exp_rc = c; exp_rid = e;
      end
      if (e == q[c][0]) begin
        void'(q[c].pop_front());
        bcnt = 1;
        pend_pop = 1;
        pend_cpu = c;
        pend_run = (q[c].size() > 0) ? q[c][0] : NONE;
      end else begin
        p = -1;
        for (int k = 1; k < q[c].size(); k++) if (q[c][k] == e) p = k;
        if (p > 0) begin
          q[c].delete(p);
          bcnt = p + 1;
        end else begin
          bcnt = q[c].size();
        end
      end
    end
  endfunction

  task automatic cyc(input bit av, input int ac, input int aid,
                     input bit ev, input int ec, input logic [31:0] ed);
    ack_valid = av; ack_cpu = CW'(ac); ack_id = 10'(aid);
    eoi_valid = ev; eoi_cpu = CW'(ec); eoi_data = ed;
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
  endtask

  task automatic ack(input int c, input int id);
    cyc(1, c, id, 0, 0, 0);
  endtask

  task automatic eoi(input int c, input logic [31:0] d);
    cyc(0, 0, 0, 1, c, d);
  endtask

  task automatic settle();
    while (bcnt > 0) idle(1);
    idle(1);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCPU; c++) exp_run[c] = NONE;
    bcnt = T; pend_pop = 0; exp_rv = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    tag = "R1 reset state";
    compare();
    rst = 0;
    tag = "R1 table clear";
    settle();

    tag = "R5 eoi while idle";
    eoi(0, 4); eoi(1, 1023); idle(2);

    tag = "R3 out-of-range ack";
    ack(0, 20); ack(0, 1023); idle(1);

    tag = "R2 ack nesting";
    ack(0, 2); ack(0, 5); ack(0, 9);
    tag = "R12 second cpu";
    ack(1, 7);

    tag = "R7 splice middle";
    eoi(0, 5);
    tag = "R11 ops while busy";
    ack(0, 3); eoi(1, 7);
    settle();

    tag = "R6 pop running";
    eoi(0, 9); settle();
    eoi(0, 2); settle();

    tag = "R10 upper bits ignored";
    eoi(1, 32'hFFFF_FC07); settle();

    tag = "R8 miss walks chain";
    ack(0, 1); ack(0, 3);
    eoi(0, 8); settle();
    eoi(0, 1023); settle();

    tag = "R4 ack wins over eoi";
    cyc(1, 0, 4, 1, 0, 3); settle();
    eoi(0, 4); settle();
    eoi(0, 3); settle();
    eoi(0, 1); settle();

    tag = "R9 level repend";
    irq_enable[3] = 1; irq_level[3] = 1; irq_target[3*NCPU + 0] = 1;
    ack(0, 3); eoi(0, 3); settle();
    tag = "R9 edge no repend";
    irq_edge[3] = 1;
    ack(0, 3); eoi(0, 3); settle();
    irq_edge[3] = 0;
    tag = "R9 other cpu target";
    irq_target[3*NCPU + 0] = 0; irq_target[3*NCPU + 1] = 1;
    ack(0, 3); eoi(0, 3); settle();
    ack(1, 3); eoi(1, 3); settle();
    tag = "R9 line low";
    irq_level[3] = 0;
    ack(1, 3); eoi(1, 3); settle();
    tag = "R9 disabled";
    irq_level[3] = 1; irq_enable[3] = 0;
    ack(1, 3); eoi(1, 3); settle();
    tag = "R9 repend on spliced id";
    irq_enable[3] = 1;
    ack(1, 3); ack(1, 6); eoi(1, 3); settle(); eoi(1, 6); settle();

    tag = "R7 deep chain";
    for (int i = 0; i < NIRQ; i++) ack(0, i);
    eoi(0, 0); settle();
    eoi(0, 8); settle();
    tag = "R12 cpu1 during cpu0 nest";
    ack(1, 11); eoi(1, 11); settle();
    tag = "R6 unwind";
    while (q[0].size() > 0) begin
      eoi(0, q[0][0]); settle();
    end
    tag = "R8 miss on long chain";
    for (int i = 0; i < NIRQ; i++) ack(1, NIRQ - 1 - i);
    eoi(1, 1023); settle();
    while (q[1].size() > 0) begin
      eoi(1, q[1][0]); settle();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule